// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt sources, lets software mask each one, raise any of them from software, and send each to either a fast-interrupt output or a normal-interrupt output. It is programmed over a simple word-addressed register bus with a combinational read path and write strobes taken on the rising clock edge.

Normal-routed sources can be bound to one of sixteen priority slots. Each slot holds a source number, an enable bit and a handler address. When the processor reads the vector register, the block returns the handler address of the best pending request and records that priority level as in service. A later write to the same register retires the most urgent level in service. Only a request more urgent than every level in service raises the normal output, so interrupt services can nest. A normal request that matches no slot is served through a default handler address. A write-protection bit can restrict register writes to privileged bus cycles. Four identification words return a fixed identity value one byte at a time.

Top module: `vector_irq_ctrl`

## Requirements
- R1: After reset every register is zero, the stack of levels in service is empty, and both `irqOut` and `fiqOut` are low.
- R2: A write to 0x10 sets the enable-mask bits written as 1 and a write to 0x14 clears them. Bits written as 0 are unchanged. A read of 0x10 returns the mask.
- R3: A write to 0x18 sets the software-interrupt bits written as 1 and a write to 0x1C clears them. A read of 0x18 returns the software bits.
- R4: A read of 0x08 returns `srcIn` OR the software bits. A read of 0x00 returns that value AND the enable mask AND NOT the route register. A read of 0x04 returns that value AND the enable mask AND the route register.
- R5: Route register 0x0C: bit n = 1 sends source n to the fast output and bit n = 0 sends it to the normal output. `fiqOut` is high exactly when the value read at 0x04 is nonzero.
- R6: Slot n has its address at 0x100+4n and its control at 0x200+4n. Control bit 5 enables the slot and bits 4:0 name the source it serves. Among enabled slots whose source has a bit set at 0x00, the lowest slot number wins. A read of 0x30 returns the winning slot's address.
- R7: A read of 0x30 while `irqOut` is high pushes the winning level onto the stack of levels in service. `irqOut` is high only when the best request is strictly more urgent (lower level) than every level in service. A write to 0x30 pops the most urgent level in service.
- R8: A normal request that no enabled slot matches takes level 16, below all slots. Reading 0x30 then returns the default address held at 0x34. A read of 0x30 while `irqOut` is low returns the default address and pushes nothing. Fast-routed sources never take part in slot arbitration.
- R9: While bit 0 of register 0x20 is set, register writes (including writes to 0x20 and 0x30) take effect only when `privIn` is high.
- R10: A read of 0xFE0+4i, for i from 0 to 3, returns byte i of the identity value 0x0005A190 in bits 7:0. Bits 19:12 of the assembled value hold the vendor code 0x5A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 12 | Byte address of the register |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe (needed for the side effect of reading 0x30) |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data |
| privIn | input | 1 | High for a privileged bus cycle |
| srcIn | input | 32 | Level interrupt sources |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
The bench checks the enable and software-interrupt registers with overlapping set and clear patterns, so that a set/clear register cannot pass if it behaves as a plain write register. It drives hardware and software sources together, with routing changed between checks, to separate raw, normal and fast status. Vector arbitration is driven with a disabled slot that names the same source as a lower-priority enabled slot, and then with a more urgent source that arrives during a service, which shows that nesting, masking by the levels in service and popping in order all work. Unmatched sources, fast-routed sources that have a slot, and unprivileged writes under protection cover the default and ignore paths.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int SRC_NUM = 32;
  localparam int DATA_W  = 32;

  // write/read strobes from the decoder to the datapath
  typedef struct packed {
    logic       selWr;
    logic       enSet;
    logic       enClr;
    logic       softSet;
    logic       softClr;
    logic       protWr;
    logic       testWr;
    logic       defWr;
    logic       vecAck;
    logic       vecRd;
    logic       slotAddrWr;
    logic       slotCtlWr;
    logic [7:0] slotIdx;
  } vicStrobes_t;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_SLOT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              privIn,
  input  logic              protOn,
  output vicStrobes_t       stb
);
  logic       wrOk;
  logic       inSlotRange;
  logic [7:0] wordIdx;

  always_comb begin
    wrOk        = busWrEn && (!protOn || privIn);
    wordIdx     = 8'(busAddr[7:2]);
    inSlotRange = (int'(wordIdx) < NUM_SLOT) && (busAddr[1:0] == 2'b00);
    stb         = '0;
    stb.slotIdx = wordIdx;
    stb.vecRd   = busRdEn && (busAddr == ADDR_W'(12'h030));
    if (wrOk) begin
      case (busAddr)
        ADDR_W'(12'h00C): stb.selWr   = 1'b1;
        ADDR_W'(12'h010): stb.enSet   = 1'b1;
        ADDR_W'(12'h014): stb.enClr   = 1'b1;
        ADDR_W'(12'h018): stb.softSet = 1'b1;
        ADDR_W'(12'h01C): stb.softClr = 1'b1;
        ADDR_W'(12'h020): stb.protWr  = 1'b1;
        ADDR_W'(12'h030): stb.vecAck  = 1'b1;
        ADDR_W'(12'h034): stb.defWr   = 1'b1;
        ADDR_W'(12'h300): stb.testWr  = 1'b1;
        default: begin
          if (busAddr[ADDR_W-1:8] == (ADDR_W-8)'(1) && inSlotRange) stb.slotAddrWr = 1'b1;
          if (busAddr[ADDR_W-1:8] == (ADDR_W-8)'(2) && inSlotRange) stb.slotCtlWr  = 1'b1;
        end
      endcase
    end
  end

  AST_PROT_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && protOn && !privIn) |-> !(stb.selWr || stb.enSet || stb.enClr || stb.softSet ||
      stb.softClr || stb.protWr || stb.testWr || stb.defWr || stb.vecAck ||
      stb.slotAddrWr || stb.slotCtlWr)); // R9

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.selWr, stb.enSet, stb.enClr, stb.softSet, stb.softClr, stb.protWr,
              stb.testWr, stb.defWr, stb.vecAck, stb.slotAddrWr, stb.slotCtlWr})); // R2
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int          NUM_SLOT = 16,
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] ID_VALUE = 32'h0005_A190
) (
  input  logic              clk,
  input  logic              rstN,
  input  vicStrobes_t       stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [SRC_NUM-1:0] srcIn,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              fiqOut,
  output logic              protOn
);
  localparam int LVL_W    = $clog2(NUM_SLOT + 2);
  localparam int SLOT_W   = $clog2(NUM_SLOT);
  localparam int DEF_LVL  = NUM_SLOT;
  localparam int IDLE_LVL = NUM_SLOT + 1;

  logic [SRC_NUM-1:0] enMask, selMask, softBits;
  logic               protBit, testBit;
  logic [DATA_W-1:0]  defAddr;
  logic [DATA_W-1:0]  slotAddr [NUM_SLOT];
  logic [5:0]         slotCtl  [NUM_SLOT];
  logic [NUM_SLOT:0]  stackMask;

  logic [SRC_NUM-1:0] rawSt, irqSt, fiqSt;
  logic [NUM_SLOT-1:0] slotHit;
  logic [SLOT_W-1:0]  winSlot;
  logic               anyHit, reqValid;
  logic [LVL_W-1:0]   curLevel, reqLevel;
  logic [DATA_W-1:0]  vecData;
  logic [5:0]         rdIdx;

  assign rawSt = srcIn | softBits;
  assign irqSt = rawSt & enMask & ~selMask;
  assign fiqSt = rawSt & enMask & selMask;

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_hit
    assign slotHit[s] = slotCtl[s][5] && irqSt[slotCtl[s][4:0]];
  end

  always_comb begin
    anyHit  = |slotHit;
    winSlot = '0;
    for (int s = NUM_SLOT - 1; s >= 0; s--)
      if (slotHit[s]) winSlot = SLOT_W'(s);
    curLevel = LVL_W'(IDLE_LVL);
    for (int l = NUM_SLOT; l >= 0; l--)
      if (stackMask[l]) curLevel = LVL_W'(l);
    if (anyHit)      reqLevel = LVL_W'(winSlot);
    else if (|irqSt) reqLevel = LVL_W'(DEF_LVL);
    else             reqLevel = LVL_W'(IDLE_LVL);
    reqValid = reqLevel < curLevel;
    vecData  = (reqValid && anyHit) ? slotAddr[winSlot] : defAddr;
  end

  assign irqOut = reqValid;
  assign fiqOut = |fiqSt;
  assign protOn = protBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask <= '0; selMask <= '0; softBits <= '0;
      protBit <= 1'b0; testBit <= 1'b0; defAddr <= '0; stackMask <= '0;
      for (int s = 0; s < NUM_SLOT; s++) begin
        slotAddr[s] <= '0;
        slotCtl[s]  <= '0;
      end
    end else begin
      if (stb.selWr)   selMask  <= wrData;
      if (stb.enSet)   enMask   <= enMask | wrData;
      if (stb.enClr)   enMask   <= enMask & ~wrData;
      if (stb.softSet) softBits <= softBits | wrData;
      if (stb.softClr) softBits <= softBits & ~wrData;
      if (stb.protWr)  protBit  <= wrData[0];
      if (stb.testWr)  testBit  <= wrData[0];
      if (stb.defWr)   defAddr  <= wrData;
      for (int s = 0; s < NUM_SLOT; s++) begin
        if (stb.slotAddrWr && int'(stb.slotIdx) == s) slotAddr[s] <= wrData;
        if (stb.slotCtlWr  && int'(stb.slotIdx) == s) slotCtl[s]  <= wrData[5:0];
      end
      if (stb.vecRd && reqValid)
        stackMask <= stackMask | ((NUM_SLOT + 1)'(1) << reqLevel);
      else if (stb.vecAck)
        stackMask <= stackMask & (stackMask - 1'b1);
    end
  end

  always_comb begin
    rdIdx  = rdAddr[7:2];
    rdData = '0;
    case (rdAddr)
      ADDR_W'(12'h000): rdData = irqSt;
      ADDR_W'(12'h004): rdData = fiqSt;
      ADDR_W'(12'h008): rdData = rawSt;
      ADDR_W'(12'h00C): rdData = selMask;
      ADDR_W'(12'h010): rdData = enMask;
      ADDR_W'(12'h018): rdData = softBits;
      ADDR_W'(12'h020): rdData = {31'b0, protBit};
      ADDR_W'(12'h030): rdData = vecData;
      ADDR_W'(12'h034): rdData = defAddr;
      ADDR_W'(12'h300): rdData = {31'b0, testBit};
      default: begin
        if (rdAddr[1:0] == 2'b00 && int'(rdIdx) < NUM_SLOT) begin
          if (rdAddr[ADDR_W-1:8] == (ADDR_W-8)'(1)) rdData = slotAddr[rdIdx[SLOT_W-1:0]];
          if (rdAddr[ADDR_W-1:8] == (ADDR_W-8)'(2)) rdData = {26'b0, slotCtl[rdIdx[SLOT_W-1:0]]};
        end
        if (rdAddr[ADDR_W-1:4] == (ADDR_W-4)'('hFE) && rdAddr[1:0] == 2'b00)
          rdData = {24'b0, ID_VALUE[8*rdAddr[3:2] +: 8]};
      end
    endcase
  end

  AST_STACK_POP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vecAck && !stb.vecRd && stackMask != '0) |=>
      $countones(stackMask) == $countones($past(stackMask)) - 1); // R7

  AST_STACK_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vecRd && irqOut) |=> $countones(stackMask) == $countones($past(stackMask)) + 1); // R7

  AST_FIQ_NO_VEC: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((rawSt & enMask & ~selMask) != '0)); // R8

  AST_SOFT_CLR: assert property (@(posedge clk) disable iff (!rstN)
    stb.softClr |=> (softBits & $past(wrData)) == '0); // R3

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rstN)
    stb.enSet |=> (enMask & $past(wrData)) == $past(wrData)); // R2
endmodule

// File: rtl/vector_irq_ctrl.sv
module vector_irq_ctrl
  import vic_pkg::*;
#(
  parameter int          NUM_SLOT = 16,
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] ID_VALUE = 32'h0005_A190
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              privIn,
  input  logic [31:0]       srcIn,
  output logic              irqOut,
  output logic              fiqOut
);
  vicStrobes_t stb;
  logic        protOn;

  vic_ctrl #(.ADDR_W(ADDR_W), .NUM_SLOT(NUM_SLOT)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .privIn(privIn), .protOn(protOn), .stb(stb)
  );

  vic_datapath #(.NUM_SLOT(NUM_SLOT), .ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWrData), .rdAddr(busAddr),
    .srcIn(srcIn), .rdData(busRdData), .irqOut(irqOut), .fiqOut(fiqOut), .protOn(protOn)
  );
endmodule

// File: tb/vector_irq_ctrl_bench.sv
module vector_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0, privIn = 1'b0;
  logic [31:0] busWrData = '0, srcIn = '0;
  logic [31:0] busRdData;
  logic        irqOut, fiqOut;
  int          nTests = 0, nFail = 0;

  localparam logic [31:0] ID_EXP = 32'h0005_A190;

  always #5 clk = ~clk;

  vector_irq_ctrl u_vector_irq_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .privIn(privIn), .srcIn(srcIn),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  // behavioural reference state
  logic [31:0] mEn = '0, mSel = '0, mSoft = '0, mDef = '0;
  logic        mProt = 1'b0, mTest = 1'b0;
  logic [31:0] mSA [16];
  logic [5:0]  mSC [16];
  int          mStack[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mIrqSt();
    return (srcIn | mSoft) & mEn & ~mSel;
  endfunction

  function automatic logic [31:0] mFiqSt();
    return (srcIn | mSoft) & mEn & mSel;
  endfunction

  function automatic void modelReq(output bit valid, output int lvl, output logic [31:0] addr);
    int cur = 17;
    logic [31:0] st = mIrqSt();
    foreach (mStack[i]) if (mStack[i] < cur) cur = mStack[i];
    lvl = 17;
    for (int s = 0; s < 16; s++)
      if (lvl == 17 && mSC[s][5] && st[mSC[s][4:0]]) lvl = s;
    if (lvl == 17 && st != 0) lvl = 16;
    valid = lvl < cur;
    addr  = (valid && lvl < 16) ? mSA[lvl] : mDef;
  endfunction

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    bit v; int l; logic [31:0] ad;
    modelReq(v, l, ad);
    if (a >= 12'h100 && a < 12'h140 && a[1:0] == 0) return mSA[a[5:2]];
    if (a >= 12'h200 && a < 12'h240 && a[1:0] == 0) return {26'b0, mSC[a[5:2]]};
    if (a >= 12'hFE0 && a[1:0] == 0) return {24'b0, ID_EXP[8*a[3:2] +: 8]};
    case (a)
      12'h000: return mIrqSt();
      12'h004: return mFiqSt();
      12'h008: return srcIn | mSoft;
      12'h00C: return mSel;
      12'h010: return mEn;
      12'h018: return mSoft;
      12'h020: return {31'b0, mProt};
      12'h030: return ad;
      12'h034: return mDef;
      12'h300: return {31'b0, mTest};
      default: return 32'h0;
    endcase
  endfunction

  task automatic step(input logic [11:0] a, input bit wr, input logic [31:0] d,
                      input bit rd, input bit priv, output logic [31:0] rdv);
    bit v; int l; logic [31:0] ad; bit wOk;
    @(negedge clk);
    busAddr = a; busWrEn = wr; busWrData = d; busRdEn = rd; privIn = priv;
    #2;
    modelReq(v, l, ad);
    check("model irqOut", {31'b0, irqOut}, {31'b0, v});
    check("model fiqOut", {31'b0, fiqOut}, {31'b0, mFiqSt() != 0});
    check("model rdData", busRdData, modelRead(a));
    rdv = busRdData;
    @(posedge clk);
    #1;
    wOk = wr && (!mProt || priv);
    if (rd && a == 12'h030 && v) mStack.push_back(l);
    else if (wOk && a == 12'h030 && mStack.size() > 0) begin
      int bi = 0;
      foreach (mStack[i]) if (mStack[i] < mStack[bi]) bi = i;
      mStack.delete(bi);
    end
    if (wOk) begin
      if (a >= 12'h100 && a < 12'h140 && a[1:0] == 0) mSA[a[5:2]] = d;
      if (a >= 12'h200 && a < 12'h240 && a[1:0] == 0) mSC[a[5:2]] = d[5:0];
      case (a)
        12'h00C: mSel = d;
        12'h010: mEn = mEn | d;
        12'h014: mEn = mEn & ~d;
        12'h018: mSoft = mSoft | d;
        12'h01C: mSoft = mSoft & ~d;
        12'h020: mProt = d[0];
        12'h034: mDef = d;
        12'h300: mTest = d[0];
        default: ;
      endcase
    end
    busWrEn = 1'b0; busRdEn = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] x;
    step(a, 1'b1, d, 1'b0, 1'b1, x);
  endtask

  task automatic rdExp(input logic [11:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] x;
    step(a, 1'b0, '0, 1'b1, 1'b0, x);
    check(tag, x, exp);
  endtask

  task automatic idle();
    logic [31:0] x;
    step(12'h000, 1'b0, '0, 1'b0, 1'b0, x);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [31:0] idv, b;
    for (int s = 0; s < 16; s++) begin mSA[s] = '0; mSC[s] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    check("R1 irqOut", {31'b0, irqOut}, 32'h0);
    check("R1 fiqOut", {31'b0, fiqOut}, 32'h0);
    rdExp(12'h010, 32'h0, "R1 enable");
    rdExp(12'h030, 32'h0, "R1 vector");

    // R2 enable set/clear
    wr(12'h010, 32'hF0);
    wr(12'h014, 32'h30);
    rdExp(12'h010, 32'hC0, "R2 enable mask");

    // R3 software set/clear
    wr(12'h018, 32'h105);
    wr(12'h01C, 32'h4);
    rdExp(12'h018, 32'h101, "R3 soft bits");
    wr(12'h01C, 32'h101);
    rdExp(12'h018, 32'h0, "R3 soft cleared");

    // R4 raw and masked status
    srcIn = 32'h41;
    wr(12'h018, 32'h2);
    rdExp(12'h008, 32'h43, "R4 raw");
    rdExp(12'h000, 32'h40, "R4 irq status");

    // R5 routing
    wr(12'h00C, 32'h40);
    rdExp(12'h004, 32'h40, "R5 fiq status");
    rdExp(12'h000, 32'h0, "R5 irq status");
    check("R5 fiqOut", {31'b0, fiqOut}, 32'h1);
    check("R5 irqOut", {31'b0, irqOut}, 32'h0);
    srcIn = 32'h0;
    wr(12'h01C, 32'h2);
    wr(12'h00C, 32'h0);
    wr(12'h014, 32'hFFFF_FFFF);

    // R6 slots
    wr(12'h20C, 32'h27); wr(12'h10C, 32'h1000);
    wr(12'h204, 32'h29); wr(12'h104, 32'h2000);
    wr(12'h200, 32'h07); wr(12'h100, 32'h3000);
    rdExp(12'h204, 32'h29, "R6 slot control");
    rdExp(12'h104, 32'h2000, "R6 slot address");
    wr(12'h034, 32'hDEF0);
    wr(12'h010, 32'h0010_1280);
    srcIn = 32'h80;
    idle();
    check("R6 irqOut raised", {31'b0, irqOut}, 32'h1);
    rdExp(12'h030, 32'h1000, "R6 enabled slot beats disabled slot");
    check("R7 masked by own level", {31'b0, irqOut}, 32'h0);

    // R7 nesting
    srcIn = 32'h280;
    idle();
    check("R7 nested request", {31'b0, irqOut}, 32'h1);
    rdExp(12'h030, 32'h2000, "R7 nested vector");
    check("R7 inner level blocks", {31'b0, irqOut}, 32'h0);
    srcIn = 32'h80;
    wr(12'h030, 32'h0);
    check("R7 outer still in service", {31'b0, irqOut}, 32'h0);
    wr(12'h030, 32'h0);
    check("R7 stack drained", {31'b0, irqOut}, 32'h1);
    srcIn = 32'h0;
    idle();

    // R8 default vector and fast sources
    srcIn = 32'h1000;
    idle();
    rdExp(12'h030, 32'hDEF0, "R8 default vector");
    check("R8 default level in service", {31'b0, irqOut}, 32'h0);
    srcIn = 32'h0;
    wr(12'h030, 32'h0);
    rdExp(12'h030, 32'hDEF0, "R8 idle read");
    wr(12'h200, 32'h34);
    wr(12'h00C, 32'h0010_0000);
    srcIn = 32'h0010_0000;
    idle();
    check("R8 fast source no irq", {31'b0, irqOut}, 32'h0);
    check("R8 fast source fiq", {31'b0, fiqOut}, 32'h1);
    srcIn = 32'h0;

    // R9 protection
    wr(12'h020, 32'h1);
    step(12'h014, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, b);
    rdExp(12'h010, 32'h0010_1280, "R9 unprivileged write ignored");
    wr(12'h014, 32'h80);
    rdExp(12'h010, 32'h0010_1200, "R9 privileged write");
    step(12'h020, 1'b1, 32'h0, 1'b0, 1'b0, b);
    rdExp(12'h020, 32'h1, "R9 protect held");

    // R10 identification
    idv = '0;
    for (int i = 0; i < 4; i++) begin
      step(12'hFE0 + 12'(4 * i), 1'b0, '0, 1'b1, 1'b0, b);
      idv[8*i +: 8] = b[7:0];
    end
    check("R10 identity", idv, 32'h0005_A190);
    check("R10 vendor", {24'b0, idv[19:12]}, 32'h5A);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule